// File: doc/BRIEF.md
# 64-bit Interval Timer

This block is a register-mapped interval timer with a 64-bit up-counter, driven through a single-cycle 32-bit register port. Software chooses a counting reference, either the bus clock or a slow tick from outside the bus clock domain, and a divider of 1 to 16. It then programs a 64-bit period as two words and starts the timer. The counter climbs from zero. On the prescaled tick where the count equals the period, the block latches a pending flag, which can drive the interrupt line. After that event the timer either wraps and keeps running, or stops until the next start.

Software reads the 64-bit count as two words without tearing. A read of the low word freezes the high half into a holding register, and the next read of the high word returns that frozen value. A software reset stops and clears the timer. It leaves the mode and period settings in place, so software can restart the timer with a single start write. The slow tick must run at no more than a third of the bus clock. It is resynchronised inside the block, and each of its rising edges counts once.

Top module: `interval_timer64`

## Requirements
- R1: After reset, every readable offset returns zero and `irq` is low. Offsets: 0x00 command, 0x04 mode, 0x08 period low, 0x0C period high, 0x10 interrupt enable, 0x1C pending status, 0x20 count low, 0x24 count high.
- R2: Writing 1 to command bit 0 clears the count and the divider and starts counting. The count low word then reads one higher for every bus-clock cycle when the divider is 1 and the bus clock is the reference.
- R3: When a tick arrives while the count equals the period N, a period event occurs and the count returns to 0. With divider 1, the first event lands N+1 cycles after the start write.
- R4: Mode bits 11:8 hold the divider value P, so a tick occurs on every (P+1)-th reference cycle. The first event then lands (N+1)(P+1) cycles after the start write.
- R5: With mode bit 0 set, the timer keeps running after an event. With it clear, the timer stops with a count of 0, and the count stays frozen until the next start.
- R6: With mode bit 3 set, the reference is `slow_tick`, taken through a two-flop synchroniser and a rising-edge detector. Each rising edge counts once, however long the level stays high.
- R7: An event sets bit 0 at offset 0x1C. A read of that offset returns the flag and clears it. If an event falls in the same cycle as that read, the flag stays set.
- R8: `irq` is high exactly when the pending flag and enable bit 0 at offset 0x10 are both set. A masked flag still reads as pending.
- R9: A read of the count low word captures the count's upper half. A later read of the count high word returns that captured half, even after the live count has carried into it.
- R10: Writing command bit 8 stops the timer and clears the count, the divider and the pending flag from the next cycle on. The mode and period registers are kept. If bit 8 and bit 0 are written together, the reset wins.
- R11: A period high-word write is only staged, and it reads back at offset 0x0C. The full period takes effect when the low word is written. Until then the timer counts against the previous period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle; read side effects happen at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| slow_tick | input | 1 | Slow reference clock, asynchronous to `clk` |
| irq | output | 1 | Period interrupt |

## Verification
The pending flag has two writers that can act in one cycle: a period event that sets it and a status read that clears it. The bench runs a continuous timer with a short period and times a status read so that it is registered on the exact edge of the second period event. That read must return 1, and a second read must also return 1, because the set has to win over the clear. A third read before the next event must return 0, which shows that the clear still works when no event coincides with it.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  // register offsets (software-visible map)
  localparam logic [7:0] OFS_CMD    = 8'h00;
  localparam logic [7:0] OFS_MODE   = 8'h04;
  localparam logic [7:0] OFS_PER_LO = 8'h08;
  localparam logic [7:0] OFS_PER_HI = 8'h0C;
  localparam logic [7:0] OFS_IEN    = 8'h10;
  localparam logic [7:0] OFS_PEND   = 8'h1C;
  localparam logic [7:0] OFS_CNT_LO = 8'h20;
  localparam logic [7:0] OFS_CNT_HI = 8'h24;

  // bit positions
  localparam int CMD_GO_BIT    = 0;
  localparam int CMD_RST_BIT   = 8;
  localparam int MODE_LOOP_BIT = 0;
  localparam int MODE_EXT_BIT  = 3;
  localparam int MODE_DIV_LSB  = 8;
  localparam int IEN_EVT_BIT   = 0;
  localparam int PEND_EVT_BIT  = 0;

  typedef struct packed {
    logic loop_en;  // continuous when set
    logic ext_ref;  // slow tick reference when set
  } mode_flags_t;
endpackage

// File: rtl/itmr_tick_gen.sv
module itmr_tick_gen #(
  parameter int PRES_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              use_ext,
  input  logic [PRES_W-1:0] div,
  input  logic              slow_tick,
  output logic              ext_pulse,
  output logic              tick
);
  // synchroniser plus one edge-detect stage
  logic [SYNC_STAGES:0] sync_q;
  logic [PRES_W-1:0]    pcnt_q;
  logic                 src_en;
  logic                 div_hit;

  function automatic logic pres_done(input logic [PRES_W-1:0] c,
                                     input logic [PRES_W-1:0] d);
    return c >= d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], slow_tick};
  end

  assign ext_pulse = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign src_en    = use_ext ? ext_pulse : 1'b1;
  assign div_hit   = pres_done(pcnt_q, div);
  assign tick      = run & src_en & div_hit & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pcnt_q <= '0;
    else if (clr)             pcnt_q <= '0;
    else if (run && src_en)   pcnt_q <= div_hit ? '0 : pcnt_q + PRES_W'(1);
  end

  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |=> !ext_pulse); // R6
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             sw_rst,
  input  logic             tick,
  input  logic             loop_en,
  input  logic [CNT_W-1:0] period,
  input  logic             pend_rd,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             period_evt,
  output logic             pend
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             pend_q;
  logic             at_period;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic             wrap);
    return wrap ? '0 : c + CNT_W'(1);
  endfunction

  assign at_period  = (cnt_q == period);
  assign period_evt = tick & at_period & ~sw_rst & ~go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (sw_rst || go)  cnt_q <= '0;
    else if (tick)          cnt_q <= advance(cnt_q, at_period);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run_q <= 1'b0;
    else if (sw_rst)                  run_q <= 1'b0;
    else if (go)                      run_q <= 1'b1;
    else if (period_evt && !loop_en)  run_q <= 1'b0;
  end

  // set has priority over read-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (sw_rst)     pend_q <= 1'b0;
    else if (period_evt) pend_q <= 1'b1;
    else if (pend_rd)    pend_q <= 1'b0;
  end

  assign cnt  = cnt_q;
  assign run  = run_q;
  assign pend = pend_q;

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (cnt_q == '0) && !run_q && !pend_q); // R10
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt && !loop_en |=> !run_q); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> cnt_q == '0); // R3
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !go && !sw_rst |=> $stable(cnt_q)); // R5
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> pend_q); // R7
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd && !period_evt && !sw_rst |=> !pend_q); // R7
endmodule

// File: rtl/interval_timer64.sv
module interval_timer64
  import itmr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int PRES_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slow_tick,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  mode_flags_t       mode_q;
  logic [PRES_W-1:0] div_q;
  logic [CNT_W-1:0]  period_q;
  logic [DATA_W-1:0] per_hi_stage_q;
  logic              ien_q;
  logic [DATA_W-1:0] snap_hi_q;

  logic              sel_cmd, sel_mode, sel_plo, sel_phi, sel_ien, sel_pend, sel_clo, sel_chi;
  logic              go, sw_rst, lo_wr, lo_rd, pend_rd;
  logic              tick, ext_pulse, run, period_evt, pend;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign sel_cmd  = bus_addr == ADDR_W'(OFS_CMD);
  assign sel_mode = bus_addr == ADDR_W'(OFS_MODE);
  assign sel_plo  = bus_addr == ADDR_W'(OFS_PER_LO);
  assign sel_phi  = bus_addr == ADDR_W'(OFS_PER_HI);
  assign sel_ien  = bus_addr == ADDR_W'(OFS_IEN);
  assign sel_pend = bus_addr == ADDR_W'(OFS_PEND);
  assign sel_clo  = bus_addr == ADDR_W'(OFS_CNT_LO);
  assign sel_chi  = bus_addr == ADDR_W'(OFS_CNT_HI);

  assign sw_rst  = bus_wr && sel_cmd && bus_wdata[CMD_RST_BIT];
  assign go      = bus_wr && sel_cmd && bus_wdata[CMD_GO_BIT] && !bus_wdata[CMD_RST_BIT];
  assign lo_wr   = bus_wr && sel_plo;
  assign lo_rd   = bus_rd && sel_clo;
  assign pend_rd = bus_rd && sel_pend;
  assign unused_wbits = ^bus_wdata;

  function automatic logic [DATA_W-1:0] mode_word(input mode_flags_t m,
                                                  input logic [PRES_W-1:0] d);
    logic [DATA_W-1:0] w;
    w = '0;
    w[MODE_LOOP_BIT]             = m.loop_en;
    w[MODE_EXT_BIT]              = m.ext_ref;
    w[MODE_DIV_LSB +: PRES_W]    = d;
    return w;
  endfunction

  // configuration registers (kept across software reset)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q         <= '0;
      div_q          <= '0;
      period_q       <= '0;
      per_hi_stage_q <= '0;
      ien_q          <= 1'b0;
    end else if (bus_wr) begin
      if (sel_mode) begin
        mode_q.loop_en <= bus_wdata[MODE_LOOP_BIT];
        mode_q.ext_ref <= bus_wdata[MODE_EXT_BIT];
        div_q          <= bus_wdata[MODE_DIV_LSB +: PRES_W];
      end
      if (sel_phi) per_hi_stage_q <= bus_wdata;
      if (sel_plo) period_q       <= {per_hi_stage_q, bus_wdata};
      if (sel_ien) ien_q          <= bus_wdata[IEN_EVT_BIT];
    end
  end

  // upper half frozen on low-word read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_hi_q <= '0;
    else if (lo_rd) snap_hi_q <= cnt[CNT_W-1:DATA_W];
  end

  itmr_tick_gen #(
    .PRES_W      (PRES_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (go | sw_rst),
    .use_ext   (mode_q.ext_ref),
    .div       (div_q),
    .slow_tick (slow_tick),
    .ext_pulse (ext_pulse),
    .tick      (tick)
  );

  itmr_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .sw_rst     (sw_rst),
    .tick       (tick),
    .loop_en    (mode_q.loop_en),
    .period     (period_q),
    .pend_rd    (pend_rd),
    .cnt        (cnt),
    .run        (run),
    .period_evt (period_evt),
    .pend       (pend)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_mode) rd_mux = mode_word(mode_q, div_q);
    if (sel_plo)  rd_mux = period_q[DATA_W-1:0];
    if (sel_phi)  rd_mux = per_hi_stage_q;
    if (sel_ien)  rd_mux[IEN_EVT_BIT]  = ien_q;
    if (sel_pend) rd_mux[PEND_EVT_BIT] = pend;
    if (sel_clo)  rd_mux = cnt[DATA_W-1:0];
    if (sel_chi)  rd_mux = snap_hi_q;
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
  assign irq       = pend & ien_q;

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd |=> $stable(snap_hi_q)); // R9
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> snap_hi_q == $past(cnt[CNT_W-1:DATA_W])); // R9
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr |=> $stable(period_q)); // R11
endmodule

// File: tb/sim_interval_timer64.sv
module sim_interval_timer64;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_addr = '0;
  logic        a_wr = 1'b0, a_rd = 1'b0;
  logic [31:0] a_wdata = '0;
  logic [31:0] a_rdata;
  logic        slow_tick = 1'b0;
  logic        irq;
  logic [7:0]  b_addr = '0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [15:0] b_wdata = '0;
  logic [15:0] b_rdata;
  logic        b_irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer64 u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr), .bus_wdata(a_wdata),
    .bus_rd(a_rd), .bus_rdata(a_rdata), .slow_tick(slow_tick), .irq(irq));

  // narrow instance so the low count half can carry within a short run
  interval_timer64 #(.DATA_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_wdata(b_wdata),
    .bus_rd(b_rd), .bus_rdata(b_rdata), .slow_tick(1'b0), .irq(b_irq));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk); a_addr = ad; a_wdata = d; a_wr = 1'b1;
    @(negedge clk); a_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ad, output logic [31:0] d);
    @(negedge clk); a_addr = ad; a_rd = 1'b1;
    #1 d = a_rdata;
    @(negedge clk); a_rd = 1'b0;
  endtask

  task automatic wr_b(input logic [7:0] ad, input logic [15:0] d);
    @(negedge clk); b_addr = ad; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic rd_b(input logic [7:0] ad, output logic [15:0] d);
    @(negedge clk); b_addr = ad; b_rd = 1'b1;
    #1 d = b_rdata;
    @(negedge clk); b_rd = 1'b0;
  endtask

  task automatic setup(input logic [31:0] mode, input logic [31:0] per);
    wr(8'h00, 32'h100);
    wr(8'h04, mode);
    wr(8'h0C, 32'h0);
    wr(8'h08, per);
    wr(8'h10, 32'h1);
  endtask

  task automatic t_reset_values();
    logic [31:0] d;
    logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h1C, 8'h20, 8'h24};
    check("R1 irq after reset", irq, 0);
    foreach (offs[i]) begin
      rd(offs[i], d);
      check("R1 reset readback", d, 0);
    end
  endtask

  task automatic t_count_rate();
    logic [31:0] d;
    setup(32'h1, 32'd1000);
    wr(8'h00, 32'h1);
    rd(8'h20, d);
    check("R2 count one cycle after start", d, 1);
    repeat (10) @(negedge clk);
    rd(8'h20, d);
    check("R2 count after 13 cycles", d, 13);
  endtask

  task automatic t_period_and_mask();
    logic [31:0] d;
    setup(32'h1, 32'd5);
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk);
    check("R3 no event before N+1", irq, 0);
    @(negedge clk);
    check("R3 event at N+1", irq, 1);
    wr(8'h10, 32'h0);
    check("R8 irq masked", irq, 0);
    rd(8'h1C, d);
    check("R8 masked flag still pending", d, 1);
    repeat (10) @(negedge clk);
    rd(8'h1C, d);
    check("R5 continuous produces another event", d, 1);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    setup(32'h1, 32'd5);
    wr(8'h00, 32'h1);
    repeat (11) @(negedge clk);
    a_addr = 8'h1C; a_rd = 1'b1;
    #1 d = a_rdata;
    @(negedge clk); a_rd = 1'b0;
    check("R7 read returns pending", d, 1);
    rd(8'h1C, d);
    check("R7 event wins over same-cycle clear", d, 1);
    rd(8'h1C, d);
    check("R7 read clears flag", d, 0);
  endtask

  task automatic t_prescaler();
    setup(32'h201, 32'd4);
    wr(8'h00, 32'h1);
    repeat (14) @(negedge clk);
    check("R4 no event before (N+1)(P+1)", irq, 0);
    @(negedge clk);
    check("R4 event at (N+1)(P+1)", irq, 1);
  endtask

  task automatic t_one_shot();
    logic [31:0] d;
    setup(32'h100, 32'd3);
    wr(8'h00, 32'h1);
    repeat (7) @(negedge clk);
    check("R5 one-shot no early event", irq, 0);
    @(negedge clk);
    check("R5 one-shot event", irq, 1);
    rd(8'h20, d);
    check("R5 one-shot count at 0", d, 0);
    repeat (20) @(negedge clk);
    rd(8'h20, d);
    check("R5 one-shot count frozen", d, 0);
    rd(8'h1C, d);
    repeat (10) @(negedge clk);
    rd(8'h1C, d);
    check("R5 one-shot no further event", d, 0);
    wr(8'h00, 32'h1);
    repeat (7) @(negedge clk);
    check("R5 restart no early event", irq, 0);
    @(negedge clk);
    check("R5 restart event", irq, 1);
  endtask

  task automatic t_ext_ref();
    logic [31:0] d;
    setup(32'h8, 32'd100);
    wr(8'h00, 32'h1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); slow_tick = 1'b1;
      repeat (3) @(negedge clk);
      @(negedge clk); slow_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd(8'h20, d);
    check("R6 five rising edges", d, 5);
    @(negedge clk); slow_tick = 1'b1;
    repeat (20) @(negedge clk);
    rd(8'h20, d);
    check("R6 held level counts once", d, 6);
    @(negedge clk); slow_tick = 1'b0;
  endtask

  task automatic t_staging();
    logic [31:0] d;
    setup(32'h1, 32'd5);
    wr(8'h0C, 32'h7);
    rd(8'h0C, d);
    check("R11 staged high readback", d, 7);
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk);
    check("R11 old period: no early event", irq, 0);
    @(negedge clk);
    check("R11 old period still active", irq, 1);
  endtask

  task automatic t_sw_reset();
    logic [31:0] d;
    setup(32'h301, 32'd2);
    wr(8'h00, 32'h1);
    repeat (30) @(negedge clk);
    wr(8'h00, 32'h100);
    check("R10 irq cleared", irq, 0);
    rd(8'h20, d);
    check("R10 count cleared", d, 0);
    rd(8'h1C, d);
    check("R10 pending cleared", d, 0);
    rd(8'h04, d);
    check("R10 mode kept", d, 32'h301);
    rd(8'h08, d);
    check("R10 period kept", d, 2);
    wr(8'h00, 32'h101);
    repeat (10) @(negedge clk);
    rd(8'h20, d);
    check("R10 reset wins over start", d, 0);
  endtask

  task automatic t_snapshot();
    logic [15:0] d;
    wr_b(8'h00, 16'h100);
    wr_b(8'h04, 16'h1);
    wr_b(8'h0C, 16'h2);
    wr_b(8'h08, 16'h0);
    wr_b(8'h00, 16'h1);
    repeat (65528) @(negedge clk);
    rd_b(8'h20, d);
    check("R9 low word before carry", d, 16'hFFF9);
    repeat (20) @(negedge clk);
    rd_b(8'h24, d);
    check("R9 high word frozen at capture", d, 0);
    rd_b(8'h20, d);
    rd_b(8'h24, d);
    check("R9 new capture after carry", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_values();
    t_count_rate();
    t_period_and_mask();
    t_collision();
    t_prescaler();
    t_one_shot();
    t_ext_ref();
    t_staging();
    t_sw_reset();
    t_snapshot();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule